// File: doc/BRIEF.md
# ADC Conversion Queue Sequencer

This block walks a short queue of conversion command words and runs a converter front end with them. Each command word names an analog channel and carries a pause bit and an end-of-queue bit. The sequencer starts a conversion, waits for end of conversion, stores the returned sample in the result slot that has the same index as the command word, and then moves on, pauses or stops. In this block the analog converter is a fixed-latency timer. When the timer finishes it captures the value on `sample_in`.

There are two ways to run the queue. In triggered mode a rising edge on `trig` starts the queue. A command word whose pause bit is set holds the live pointer after its conversion, and only the next trigger edge releases it. In gated modes a level on `gate` opens a scan window. Closing the gate lets the current conversion finish and then stops the queue. If the pass was not complete, the pause flag records that. Reopening the gate always restarts from command word 0. Gated single-scan runs one full pass for each arming of the single-scan enable. Gated continuous mode wraps around for as long as the gate stays open.

The block keeps two pointers. The live pointer names the command word being converted. The completed pointer names the last command word whose result was written, so it lags the live pointer.

Top module: `adc_queue_seq`

## Requirements
- R1: Command word x sits at `ccw_table[x*CCW_W +: CCW_W]`, with CCW_W = CH_W+2. Bits [CH_W-1:0] hold the channel, bit CH_W is the pause bit and bit CH_W+1 is the end-of-queue bit. `conv_chan` shows the channel of the command word being converted, and `conv_start` pulses for one cycle each time a conversion starts.
- R2: `eoc` pulses for one cycle exactly CONV_CYCLES (default 14) cycles after the `conv_start` pulse of the same conversion.
- R3: The sample captured at the end of command word x's conversion goes into result slot x. `res_rdata` returns slot `res_raddr` one cycle after the address is applied.
- R4: `cwp_done` changes only on the edge that ends an `eoc` cycle, and it takes the index of the command word just finished. Whenever `busy` is low, `cwp_done` equals `cwp`.
- R5: Triggered mode, pause bit set. After that word's conversion, `cwp` holds, `pf` sets and `busy` drops. The next `trig` rising edge moves `cwp` to the next index and starts it.
- R6: Triggered mode, pause bit clear and not the end of the queue. `cwp` advances at that word's end of conversion, and the next conversion starts with no trigger.
- R7: Triggered mode. A `trig` edge during a conversion has no effect. From idle, a `trig` rising edge starts the queue at word 0 only when `sse` is set.
- R8: A word ends the queue if its end-of-queue bit is set or it is the last index (NUM_CCW-1). Finishing it sets `cf`. In triggered and gated single-scan modes it also clears `sse` and leaves the queue idle, even with the gate still open.
- R9: Gated modes. If `gate` is low at any time during a conversion, that conversion still completes and writes its result, and then the queue goes idle. If that word did not end the queue, `pf` sets.
- R10: Gated modes. When an idle queue sees the gate open (with `sse` set in single-scan mode), it starts at word 0, whatever position was interrupted.
- R11: Gated continuous mode. After the end word, `cf` sets and scanning wraps to word 0 while the gate stays open. `sse` is left unchanged.
- R12: Synchronous reset clears `cwp`, `cwp_done`, `cf`, `pf` and `sse`, and makes the queue idle. A `flag_clr` pulse clears `cf` and `pf`. An `sse_set` pulse sets `sse`.
- R13: `mode` encoding: 0 is triggered, 1 is gated single-scan, 2 is gated continuous, and 3 behaves as 0. In gated modes, pause bits and `trig` have no effect. In triggered mode, `gate` has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode | input | 2 | Scan mode (R13), changed only while idle |
| trig | input | 1 | External trigger, rising edge used |
| gate | input | 1 | External gate level |
| sse_set | input | 1 | Pulse that arms single-scan enable |
| flag_clr | input | 1 | Pulse that clears completion and pause flags |
| ccw_table | input | NUM_CCW*(CH_W+2) | Packed command word queue |
| sample_in | input | DATA_W | Sample returned by the converter front end |
| res_raddr | input | $clog2(NUM_CCW) | Result slot read address |
| conv_start | output | 1 | Conversion start pulse |
| conv_chan | output | CH_W | Channel of the current conversion |
| eoc | output | 1 | End-of-conversion pulse |
| busy | output | 1 | A conversion is in progress |
| cwp | output | $clog2(NUM_CCW) | Live command word pointer |
| cwp_done | output | $clog2(NUM_CCW) | Completed command word pointer |
| cf | output | 1 | Queue completion flag |
| pf | output | 1 | Pause / incomplete-pass flag |
| sse | output | 1 | Single-scan enable |
| res_rdata | output | DATA_W | Result slot read data |

## Verification
The bench builds the block with a four-entry queue, 3-bit channels, 8-bit samples and the full 14-cycle conversion time. With four entries every slot is written and read back. Both end conditions can be reached: the end-of-queue bit, and running off the last index. The continuous wrap can be seen more than once within a few hundred cycles. The sample is a fixed arithmetic function of the channel, so every slot's expected value follows directly from the command words the bench loads.

// File: rtl/adc_queue_seq_pkg.sv
`timescale 1ns/1ps
package adc_queue_seq_pkg;

  typedef enum logic [1:0] {
    MODE_TRIG    = 2'd0,
    MODE_GSINGLE = 2'd1,
    MODE_GCONT   = 2'd2,
    MODE_RSVD    = 2'd3
  } scan_mode_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_CONV  = 2'd1,
    ST_PAUSE = 2'd2
  } seq_state_e;

endpackage

// File: rtl/adc_queue_seq_ccw_sel.sv
`timescale 1ns/1ps
module adc_queue_seq_ccw_sel #(
  parameter int NUM_CCW = 8,
  parameter int CCW_W   = 6,
  parameter int IDX_W   = $clog2(NUM_CCW)
) (
  input  logic [NUM_CCW*CCW_W-1:0] table_flat,
  input  logic [IDX_W-1:0]         idx,
  output logic [CCW_W-1:0]         word
);

  logic [CCW_W-1:0] entry [NUM_CCW];

  for (genvar g = 0; g < NUM_CCW; g++) begin : g_unpack
    assign entry[g] = table_flat[g*CCW_W +: CCW_W];
  end

  assign word = entry[idx];

endmodule

// File: rtl/adc_queue_seq_conv_timer.sv
`timescale 1ns/1ps
module adc_queue_seq_conv_timer #(
  parameter int CONV_CYCLES = 14,
  parameter int CH_W        = 4,
  parameter int DATA_W      = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [CH_W-1:0]   start_chan,
  input  logic [DATA_W-1:0] sample_in,
  output logic              conv_start,
  output logic [CH_W-1:0]   conv_chan,
  output logic              eoc,
  output logic [DATA_W-1:0] sample
);

  localparam int CNT_W = $clog2(CONV_CYCLES + 1);
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(CONV_CYCLES);
  localparam logic [CNT_W-1:0] CNT_ONE  = CNT_W'(1);

  logic [CNT_W-1:0] cnt;
  logic             run;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt        <= '0;
      run        <= 1'b0;
      conv_start <= 1'b0;
      conv_chan  <= '0;
      eoc        <= 1'b0;
      sample     <= '0;
    end else begin
      conv_start <= start;
      eoc        <= 1'b0;
      if (start) begin
        run       <= 1'b1;
        cnt       <= CNT_LOAD;
        conv_chan <= start_chan;
      end else if (run) begin
        cnt <= cnt - CNT_ONE;
        if (cnt == CNT_ONE) begin
          eoc    <= 1'b1;
          run    <= 1'b0;
          sample <= sample_in;
        end
      end
    end
  end

endmodule

// File: rtl/adc_queue_seq_result_ram.sv
`timescale 1ns/1ps
module adc_queue_seq_result_ram #(
  parameter int DEPTH  = 8,
  parameter int DATA_W = 10,
  parameter int AW     = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              we,
  input  logic [AW-1:0]     waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [AW-1:0]     raddr,
  output logic [DATA_W-1:0] rdata
);

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end

endmodule

// File: rtl/adc_queue_seq.sv
`timescale 1ns/1ps
module adc_queue_seq
  import adc_queue_seq_pkg::*;
#(
  parameter int NUM_CCW     = 8,
  parameter int CH_W        = 4,
  parameter int DATA_W      = 10,
  parameter int CONV_CYCLES = 14
) (
  input  logic                                clk,
  input  logic                                rst,
  input  logic [1:0]                          mode,
  input  logic                                trig,
  input  logic                                gate,
  input  logic                                sse_set,
  input  logic                                flag_clr,
  input  logic [NUM_CCW*(CH_W+2)-1:0]         ccw_table,
  input  logic [DATA_W-1:0]                   sample_in,
  input  logic [$clog2(NUM_CCW)-1:0]          res_raddr,
  output logic                                conv_start,
  output logic [CH_W-1:0]                     conv_chan,
  output logic                                eoc,
  output logic                                busy,
  output logic [$clog2(NUM_CCW)-1:0]          cwp,
  output logic [$clog2(NUM_CCW)-1:0]          cwp_done,
  output logic                                cf,
  output logic                                pf,
  output logic                                sse,
  output logic [DATA_W-1:0]                   res_rdata
);

  localparam int CCW_W     = CH_W + 2;
  localparam int IDX_W     = $clog2(NUM_CCW);
  localparam int PAUSE_BIT = CH_W;
  localparam int EOQ_BIT   = CH_W + 1;
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_CCW - 1);
  localparam logic [IDX_W-1:0] ONE_IDX  = IDX_W'(1);

  seq_state_e  state;
  scan_mode_e  mode_e;
  logic        trig_q;
  logic        stop_req;
  logic        trig_rise;
  logic        gated_m;
  logic        cont_m;
  logic        closed;
  logic        start;
  logic [IDX_W-1:0] nxt_idx;
  logic [CCW_W-1:0] cur_ccw;
  logic [CCW_W-1:0] nxt_ccw;
  logic        is_end;
  logic        is_pause;
  logic        eoc_w;
  logic [DATA_W-1:0] conv_sample;
  logic        res_we;
  logic        unused_bits;

  assign mode_e    = scan_mode_e'(mode);
  assign gated_m   = (mode_e == MODE_GSINGLE) || (mode_e == MODE_GCONT);
  assign cont_m    = (mode_e == MODE_GCONT);
  assign trig_rise = trig & ~trig_q;
  assign closed    = stop_req | ~gate;

  adc_queue_seq_ccw_sel #(.NUM_CCW(NUM_CCW), .CCW_W(CCW_W), .IDX_W(IDX_W)) cur_sel_i (
    .table_flat (ccw_table),
    .idx        (cwp),
    .word       (cur_ccw)
  );

  adc_queue_seq_ccw_sel #(.NUM_CCW(NUM_CCW), .CCW_W(CCW_W), .IDX_W(IDX_W)) nxt_sel_i (
    .table_flat (ccw_table),
    .idx        (nxt_idx),
    .word       (nxt_ccw)
  );

  assign unused_bits = ^{cur_ccw[CH_W-1:0], nxt_ccw[CCW_W-1:CH_W]};

  assign is_end   = cur_ccw[EOQ_BIT] | (cwp == LAST_IDX);
  assign is_pause = cur_ccw[PAUSE_BIT] & ~gated_m;

  // Next-step decision: whether a conversion starts this cycle and at which index.
  always_comb begin
    start   = 1'b0;
    nxt_idx = cwp;
    unique case (state)
      ST_IDLE: begin
        nxt_idx = '0;
        if (gated_m) start = gate & (cont_m | sse);
        else         start = sse & trig_rise;
      end
      ST_CONV: begin
        if (eoc_w) begin
          if (!is_end) begin
            nxt_idx = cwp + ONE_IDX;
            start   = gated_m ? ~closed : ~is_pause;
          end else begin
            nxt_idx = '0;
            start   = cont_m & ~closed;
          end
        end
      end
      ST_PAUSE: begin
        nxt_idx = cwp + ONE_IDX;
        start   = trig_rise;
      end
      default: begin
        start   = 1'b0;
        nxt_idx = cwp;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      cwp      <= '0;
      cwp_done <= '0;
      cf       <= 1'b0;
      pf       <= 1'b0;
      sse      <= 1'b0;
      stop_req <= 1'b0;
      trig_q   <= 1'b0;
    end else begin
      trig_q <= trig;
      if (flag_clr) begin
        cf <= 1'b0;
        pf <= 1'b0;
      end
      if (sse_set) sse <= 1'b1;
      if (state == ST_CONV && gated_m && !gate) stop_req <= 1'b1;

      if (state == ST_CONV && eoc_w) begin
        cwp_done <= cwp;
        if (is_end) begin
          cf <= 1'b1;
          if (!cont_m) sse <= 1'b0;
        end else if (is_pause || (gated_m && closed)) begin
          pf <= 1'b1;
        end
      end

      if (start) begin
        cwp      <= nxt_idx;
        stop_req <= 1'b0;
        state    <= ST_CONV;
      end else if (state == ST_CONV && eoc_w) begin
        state <= (is_pause && !is_end) ? ST_PAUSE : ST_IDLE;
      end
    end
  end

  assign busy = (state == ST_CONV);

  adc_queue_seq_conv_timer #(.CONV_CYCLES(CONV_CYCLES), .CH_W(CH_W), .DATA_W(DATA_W)) timer_i (
    .clk        (clk),
    .rst        (rst),
    .start      (start),
    .start_chan (nxt_ccw[CH_W-1:0]),
    .sample_in  (sample_in),
    .conv_start (conv_start),
    .conv_chan  (conv_chan),
    .eoc        (eoc_w),
    .sample     (conv_sample)
  );

  assign eoc    = eoc_w;
  assign res_we = (state == ST_CONV) && eoc_w;

  adc_queue_seq_result_ram #(.DEPTH(NUM_CCW), .DATA_W(DATA_W), .AW(IDX_W)) res_i (
    .clk   (clk),
    .we    (res_we),
    .waddr (cwp),
    .wdata (conv_sample),
    .raddr (res_raddr),
    .rdata (res_rdata)
  );

endmodule

// File: rtl/adc_queue_seq_chk.sv
`timescale 1ns/1ps
module adc_queue_seq_chk #(
  parameter int NUM_CCW     = 8,
  parameter int CONV_CYCLES = 14,
  parameter int IDX_W       = $clog2(NUM_CCW)
) (
  input logic             clk,
  input logic             rst,
  input logic [1:0]       mode,
  input logic             sse_set,
  input logic             conv_start,
  input logic             eoc,
  input logic             busy,
  input logic [IDX_W-1:0] cwp,
  input logic [IDX_W-1:0] cwp_done,
  input logic             cf,
  input logic             pf,
  input logic             sse
);

  localparam int CW = $clog2(CONV_CYCLES + 2) + 1;
  logic [CW-1:0] since_start;

  always_ff @(posedge clk) begin
    if (rst) since_start <= '0;
    else if (conv_start) since_start <= CW'(1);
    else if (since_start != '0 && since_start <= CW'(CONV_CYCLES)) since_start <= since_start + CW'(1);
  end

  // R2
  conv_latency_chk: assert property (@(posedge clk) disable iff (rst)
    eoc |-> since_start == CW'(CONV_CYCLES));

  // R4
  ptr_match_chk: assert property (@(posedge clk) disable iff (rst)
    !busy |-> cwp == cwp_done);

  // R4
  done_ptr_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !eoc |=> $stable(cwp_done));

  // R7
  live_ptr_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && !eoc) |=> $stable(cwp));

  // R8
  single_sse_clear_chk: assert property (@(posedge clk) disable iff (rst)
    ($rose(cf) && mode != 2'd2) |-> !sse);

  // R11
  cont_sse_keep_chk: assert property (@(posedge clk) disable iff (rst)
    ($rose(cf) && mode == 2'd2 && !$past(sse_set)) |-> $stable(sse));

  // R12
  reset_state_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!cf && !pf && !sse && !busy && cwp == '0 && cwp_done == '0));

endmodule

bind adc_queue_seq adc_queue_seq_chk #(
  .NUM_CCW(NUM_CCW), .CONV_CYCLES(CONV_CYCLES)
) chk_i (
  .clk(clk), .rst(rst), .mode(mode), .sse_set(sse_set),
  .conv_start(conv_start), .eoc(eoc), .busy(busy),
  .cwp(cwp), .cwp_done(cwp_done), .cf(cf), .pf(pf), .sse(sse)
);

// File: tb/adc_queue_seq_tb_top.sv
`timescale 1ns/1ps
module adc_queue_seq_tb_top;

  localparam int NC   = 4;
  localparam int CHW  = 3;
  localparam int DW   = 8;
  localparam int CONV = 14;
  localparam int CW   = CHW + 2;
  localparam int IW   = 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [1:0] mode = 2'd0;
  logic trig = 1'b0, gate = 1'b0, sse_set = 1'b0, flag_clr = 1'b0;
  logic [NC*CW-1:0] ccw_table = '0;
  logic [DW-1:0] sample_in;
  logic [IW-1:0] res_raddr = '0;
  logic conv_start, eoc, busy, cf, pf, sse;
  logic [CHW-1:0] conv_chan;
  logic [IW-1:0] cwp, cwp_done;
  logic [DW-1:0] res_rdata;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  function automatic logic [DW-1:0] fsamp(input int ch);
    return DW'(ch * 29 + 11);
  endfunction

  function automatic logic [CW-1:0] mk(input int ch, input bit pause, input bit eoq);
    return {eoq, pause, CHW'(ch)};
  endfunction

  assign sample_in = fsamp(int'(conv_chan));

  adc_queue_seq #(.NUM_CCW(NC), .CH_W(CHW), .DATA_W(DW), .CONV_CYCLES(CONV)) dut_i (
    .clk(clk), .rst(rst), .mode(mode), .trig(trig), .gate(gate),
    .sse_set(sse_set), .flag_clr(flag_clr), .ccw_table(ccw_table),
    .sample_in(sample_in), .res_raddr(res_raddr),
    .conv_start(conv_start), .conv_chan(conv_chan), .eoc(eoc), .busy(busy),
    .cwp(cwp), .cwp_done(cwp_done), .cf(cf), .pf(pf), .sse(sse),
    .res_rdata(res_rdata)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_trig();
    trig = 1'b1; tick(1); trig = 1'b0;
  endtask

  task automatic pulse_sse();
    sse_set = 1'b1; tick(1); sse_set = 1'b0;
  endtask

  task automatic pulse_clr();
    flag_clr = 1'b1; tick(1); flag_clr = 1'b0;
  endtask

  task automatic wait_eoc(output int cyc);
    cyc = 0;
    for (int i = 0; i < 200; i++) begin
      tick(1);
      cyc++;
      if (eoc) break;
    end
    if (!eoc) chk("R2 eoc timeout", 0, 1);
  endtask

  task automatic read_slot(input int idx, input int exp, input string req);
    res_raddr = IW'(idx);
    tick(1);
    chk(req, int'(res_rdata), exp);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    int c;
    tick(3);
    // R12 reset state
    chk("R12 cwp", int'(cwp), 0);
    chk("R12 cwp_done", int'(cwp_done), 0);
    chk("R12 flags", int'({cf, pf, sse, busy}), 0);
    rst = 1'b0;
    tick(2);

    // ---------- Triggered mode with pause ----------
    ccw_table = {mk(0, 0, 0), mk(6, 0, 1), mk(2, 0, 0), mk(5, 1, 0)};
    mode = 2'd0;
    pulse_trig();
    tick(2);
    chk("R7 idle trig needs sse", int'(busy), 0);
    pulse_sse();
    pulse_trig();
    chk("R1 conv_start", int'(conv_start), 1);
    chk("R1 conv_chan word0", int'(conv_chan), 5);
    chk("R7 start at word0", int'(cwp), 0);
    wait_eoc(c);
    chk("R2 latency", c, CONV);
    tick(1);
    chk("R5 busy after pause", int'(busy), 0);
    chk("R5 pf set", int'(pf), 1);
    chk("R5 cwp held", int'(cwp), 0);
    chk("R4 done ptr", int'(cwp_done), 0);
    tick(5);
    chk("R5 cwp still held", int'(cwp), 0);
    pulse_trig();
    chk("R5 trig releases", int'(busy), 1);
    chk("R5 cwp advanced", int'(cwp), 1);
    chk("R1 conv_chan word1", int'(conv_chan), 2);
    chk("R4 done lags", int'(cwp_done), 0);
    tick(3);
    pulse_trig();
    tick(1);
    chk("R7 trig while busy", int'(cwp), 1);
    wait_eoc(c);
    tick(1);
    chk("R6 auto advance", int'(cwp), 2);
    chk("R6 busy", int'(busy), 1);
    chk("R4 done at eoc", int'(cwp_done), 1);
    wait_eoc(c);
    tick(1);
    chk("R8 idle", int'(busy), 0);
    chk("R8 cf", int'(cf), 1);
    chk("R8 sse cleared", int'(sse), 0);
    chk("R4 ptrs equal", int'(cwp_done), 2);
    read_slot(0, int'(fsamp(5)), "R3 slot0");
    read_slot(1, int'(fsamp(2)), "R3 slot1");
    read_slot(2, int'(fsamp(6)), "R3 slot2");
    pulse_trig();
    tick(3);
    chk("R7 no restart without sse", int'(busy), 0);

    pulse_clr();
    chk("R12 flag_clr", int'({cf, pf}), 0);

    // ---------- Gated single scan ----------
    ccw_table = {mk(7, 0, 1), mk(4, 0, 0), mk(3, 1, 0), mk(1, 0, 0)};
    mode = 2'd1;
    pulse_sse();
    gate = 1'b1;
    tick(1);
    chk("R10 gate starts", int'(busy), 1);
    chk("R10 start word0", int'(cwp), 0);
    wait_eoc(c);
    tick(1);
    chk("R13 next word", int'(cwp), 1);
    tick(1);
    wait_eoc(c);
    tick(1);
    chk("R13 pause ignored gated", int'(busy), 1);
    chk("R13 pf not set", int'(pf), 0);
    tick(3);
    gate = 1'b0;
    pulse_trig();
    wait_eoc(c);
    chk("R9 conversion finishes", int'(eoc), 1);
    tick(1);
    chk("R9 idle after close", int'(busy), 0);
    chk("R9 pf set", int'(pf), 1);
    chk("R9 cf clear", int'(cf), 0);
    chk("R9 done ptr", int'(cwp_done), 2);
    read_slot(2, int'(fsamp(4)), "R9 slot2 written");
    tick(5);
    chk("R9 stays idle", int'(busy), 0);
    gate = 1'b1;
    tick(1);
    chk("R10 restart busy", int'(busy), 1);
    chk("R10 restart word0", int'(cwp), 0);
    for (int k = 0; k < 4; k++) begin
      wait_eoc(c);
      tick(1);
      chk("R4 done sequence", int'(cwp_done), k);
    end
    chk("R8 single done idle", int'(busy), 0);
    chk("R8 single cf", int'(cf), 1);
    chk("R8 single sse cleared", int'(sse), 0);
    read_slot(0, int'(fsamp(1)), "R3 gslot0");
    read_slot(1, int'(fsamp(3)), "R3 gslot1");
    read_slot(2, int'(fsamp(4)), "R3 gslot2");
    read_slot(3, int'(fsamp(7)), "R3 gslot3");
    tick(20);
    chk("R8 no rerun gate open", int'(busy), 0);

    // ---------- Gated continuous ----------
    flag_clr = 1'b1;
    mode = 2'd2;
    tick(1);
    flag_clr = 1'b0;
    chk("R11 starts", int'(busy), 1);
    for (int k = 0; k < 6; k++) begin
      wait_eoc(c);
      tick(1);
      chk("R11 wrap sequence", int'(cwp_done), k % 4);
      chk("R11 still busy", int'(busy), 1);
      if (k == 3) begin
        chk("R11 cf", int'(cf), 1);
        chk("R11 sse unchanged", int'(sse), 0);
        chk("R11 wrapped to word0", int'(cwp), 0);
      end
    end
    gate = 1'b0;
    wait_eoc(c);
    tick(1);
    chk("R9 cont stop", int'(busy), 0);
    chk("R9 cont done ptr", int'(cwp_done), 2);
    chk("R4 idle ptrs", int'(cwp), int'(cwp_done));
    chk("R9 cont pf", int'(pf), 1);

    // ---------- Triggered, end by last index, gate ignored ----------
    pulse_clr();
    mode = 2'd0;
    ccw_table = {mk(6, 0, 0), mk(4, 0, 0), mk(2, 0, 0), mk(0, 0, 0)};
    gate = 1'b1;
    pulse_sse();
    pulse_trig();
    gate = 1'b0;
    for (int k = 0; k < 4; k++) begin
      wait_eoc(c);
      tick(1);
      chk("R8 last idx sequence", int'(cwp_done), k);
    end
    chk("R8 last idx idle", int'(busy), 0);
    chk("R8 last idx cf", int'(cf), 1);
    chk("R13 no pf", int'(pf), 0);
    read_slot(0, int'(fsamp(0)), "R3 tslot0");
    read_slot(3, int'(fsamp(6)), "R3 tslot3");

    // ---------- Reset mid scan ----------
    mode = 2'd2;
    gate = 1'b1;
    tick(20);
    chk("R12 running before reset", int'(busy), 1);
    rst = 1'b1;
    gate = 1'b0;
    tick(2);
    chk("R12 reset ptrs", int'({cwp, cwp_done}), 0);
    chk("R12 reset flags", int'({cf, pf, sse, busy}), 0);
    rst = 1'b0;
    tick(3);
    chk("R12 idle after reset", int'(busy), 0);

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule